// File: doc/BRIEF.md
# Asynchronous Static Memory Access Sequencer

This block converts internal 32-bit read and write requests into timed access cycles on an external asynchronous memory bus (SRAM, flash and similar parts). It drives active-low chip selects, an active-low output enable, an active-low write enable, a direction pin, a word address, a two-bit byte-lane address and a 16-bit data bus. Each of the chip-select spaces carries its own configuration word. That word sets separate setup, strobe and hold lengths for reads and for writes, a turnaround length, an 8/16-bit bus width and a strobe-style chip-select mode.

A request is accepted through a valid/ready handshake. It carries a 32-bit address, 32-bit write data, a write flag and a chip-select index. On a narrow bus the block splits the word into two halfword or four byte accesses, in ascending order. For a read, it assembles the returned pieces into one 32-bit result and presents it with a one-cycle response pulse. A single `strobe_extend` input stands in for external wait-pin logic: while it is high during a strobe, the strobe countdown is frozen.

Top module: `asram_seq`

## Requirements
- R1: The configuration word of a space is 30 bits: [29] strobe-style select, [28] wide bus, [27:24] turnaround, [23:20] read setup, [19:16] read strobe, [15:12] read hold, [11:8] write setup, [7:4] write strobe, [3:0] write hold. A phase field of N gives N+1 cycles. Reads use the read fields and writes use the write fields.
- R2: Before setup, the block spends turnaround+1 idle-bus cycles with `req_ready` low. This is skipped only when the previous request went to the same space in the same direction. After reset, the first request always takes the turnaround.
- R3: With strobe-style select at 0, the selected `mem_cs_n` bit is low from the first setup cycle to the last hold cycle of the request. No other chip select is ever low.
- R4: With strobe-style select at 1, the selected `mem_cs_n` bit is low only in strobe cycles.
- R5: `mem_oe_n` is low only in read strobe cycles and `mem_we_n` only in write strobe cycles. `mem_rw` is 1 for read or idle and 0 from the first setup to the last hold of a write.
- R6: Read data is captured on the last strobe cycle. In the cycle after the final hold, `rsp_valid` pulses for one cycle, with byte k of the word in `rsp_rdata[8k+7:8k]`.
- R7: During an access, `mem_addr` equals `req_addr[23:2]`. On an 8-bit bus (wide=0) there are four accesses with `mem_ba` = 0,1,2,3. On a 16-bit bus there are two accesses with `mem_ba` = 00 then 10. Address outputs are 0 outside accesses.
- R8: Each cycle that `strobe_extend` is high during a strobe adds one strobe cycle.
- R9: The configuration is captured when a request is accepted. Changing it during the request has no effect until the next request.
- R10: `req_ready` is high exactly when no request is in progress.
- R11: During a write access, `mem_doe` is 1 and `mem_dout` carries the byte in [7:0] with [15:8] zero (8-bit bus) or the halfword (16-bit bus). Outside a write access both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_flat | input | 120 | Configuration words, space i at bits [30i+29:30i] |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with valid |
| req_addr | input | 32 | Byte address (word aligned) |
| req_wdata | input | 32 | Write data |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cs | input | 2 | Chip-select space index |
| rsp_valid | output | 1 | One-cycle read completion pulse |
| rsp_rdata | output | 32 | Assembled read data |
| strobe_extend | input | 1 | Freezes the strobe countdown while high |
| mem_cs_n | output | 4 | Active-low chip selects |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_rw | output | 1 | Direction: 1 read/idle, 0 write |
| mem_addr | output | 22 | Word address |
| mem_ba | output | 2 | Byte-lane address |
| mem_dout | output | 16 | Write data to the bus |
| mem_doe | output | 1 | Data bus drive enable |
| mem_din | input | 16 | Read data from the bus |

## Verification
The hardest case to reach is a configuration change that lands in the middle of a multi-piece access. To land a change there, the request task returns as soon as the request is accepted and the expected cycle stream has been queued. The bench then rewrites that space's timing while the bus is still busy, and the per-cycle comparison shows whether the remaining pieces kept the old lengths. The memory model returns a poison value whenever the output enable is high, so capturing data one cycle late shows up directly in the assembled word.

// File: rtl/asram_pkg.sv
package asram_pkg;
    localparam int PH_W   = 4;
    localparam int DQ_W   = 16;
    localparam int WORD_W = 32;

    typedef struct packed {
        logic            sel_strobe;
        logic            wide;
        logic [PH_W-1:0] turn;
        logic [PH_W-1:0] rd_setup;
        logic [PH_W-1:0] rd_strobe;
        logic [PH_W-1:0] rd_hold;
        logic [PH_W-1:0] wr_setup;
        logic [PH_W-1:0] wr_strobe;
        logic [PH_W-1:0] wr_hold;
    } asram_cfg_t;

    localparam int CFG_W = $bits(asram_cfg_t);

    typedef struct packed {
        logic [PH_W-1:0] setup;
        logic [PH_W-1:0] strobe;
        logic [PH_W-1:0] hold;
    } timing_t;

    typedef enum logic [2:0] {
        PH_IDLE, PH_TURN, PH_SETUP, PH_STROBE, PH_HOLD
    } phase_e;

    function automatic timing_t pick_timing(asram_cfg_t c, logic wr);
        timing_t t;
        t.setup  = wr ? c.wr_setup  : c.rd_setup;
        t.strobe = wr ? c.wr_strobe : c.rd_strobe;
        t.hold   = wr ? c.wr_hold   : c.rd_hold;
        return t;
    endfunction

    function automatic logic [1:0] final_piece(logic wide);
        return wide ? 2'd1 : 2'd3;
    endfunction
endpackage

// File: rtl/asram_ctrl.sv
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int NCS  = 4,
    parameter int CS_W = $clog2(NCS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    input  logic            req_write,
    input  logic [CS_W-1:0] req_cs,
    input  asram_cfg_t      req_cfg,
    input  logic            strobe_extend,
    output logic            req_ready,
    output phase_e          phase,
    output logic [1:0]      sub_idx,
    output logic [CS_W-1:0] cur_cs,
    output logic            cur_wr,
    output logic            cur_ss,
    output logic            cur_wide,
    output logic            sample_en,
    output logic            done
);
    logic [PH_W-1:0] cnt;
    timing_t         tim;
    timing_t         t_new;
    logic            last_vld;
    logic [CS_W-1:0] last_cs;
    logic            last_wr;
    logic            need_turn;
    logic            last_piece;

    assign t_new      = pick_timing(req_cfg, req_write);
    assign need_turn  = !(last_vld && last_cs == req_cs && last_wr == req_write);
    assign last_piece = (sub_idx == final_piece(cur_wide));
    assign req_ready  = (phase == PH_IDLE);
    assign sample_en  = (phase == PH_STROBE) && (cnt == '0) && !strobe_extend;
    assign done       = (phase == PH_HOLD) && (cnt == '0) && last_piece;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            cnt      <= '0;
            sub_idx  <= '0;
            cur_cs   <= '0;
            cur_wr   <= 1'b0;
            cur_ss   <= 1'b0;
            cur_wide <= 1'b0;
            tim      <= '0;
            last_vld <= 1'b0;
            last_cs  <= '0;
            last_wr  <= 1'b0;
        end else begin
            case (phase)
                PH_IDLE: if (req_valid) begin
                    cur_cs   <= req_cs;
                    cur_wr   <= req_write;
                    cur_ss   <= req_cfg.sel_strobe;
                    cur_wide <= req_cfg.wide;
                    tim      <= t_new;
                    sub_idx  <= '0;
                    if (need_turn) begin
                        phase <= PH_TURN;
                        cnt   <= req_cfg.turn;
                    end else begin
                        phase <= PH_SETUP;
                        cnt   <= t_new.setup;
                    end
                end
                PH_TURN: if (cnt == '0) begin
                    phase <= PH_SETUP;
                    cnt   <= tim.setup;
                end else begin
                    cnt <= cnt - 1'b1;
                end
                PH_SETUP: if (cnt == '0) begin
                    phase <= PH_STROBE;
                    cnt   <= tim.strobe;
                end else begin
                    cnt <= cnt - 1'b1;
                end
                PH_STROBE: if (!strobe_extend) begin
                    if (cnt == '0) begin
                        phase <= PH_HOLD;
                        cnt   <= tim.hold;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_HOLD: if (cnt == '0) begin
                    if (last_piece) begin
                        phase    <= PH_IDLE;
                        last_vld <= 1'b1;
                        last_cs  <= cur_cs;
                        last_wr  <= cur_wr;
                    end else begin
                        sub_idx <= sub_idx + 1'b1;
                        phase   <= PH_SETUP;
                        cnt     <= tim.setup;
                    end
                end else begin
                    cnt <= cnt - 1'b1;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/asram_lane.sv
module asram_lane
    import asram_pkg::*;
#(
    parameter int ADDR_W = 22
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [ADDR_W-1:0] word_addr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              wide,
    input  logic [1:0]        sub_idx,
    input  logic              active,
    input  logic              wr,
    input  logic              sample_en,
    input  logic [DQ_W-1:0]   din,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        mem_ba,
    output logic [DQ_W-1:0]   mem_dout,
    output logic [WORD_W-1:0] rdata
);
    localparam int NBYTE = WORD_W / 8;

    logic [ADDR_W-1:0]      wa_q;
    logic [WORD_W-1:0]      wd_q;
    logic [NBYTE-1:0][7:0]  rbytes;
    logic [DQ_W-1:0]        piece;

    always_ff @(posedge clk) begin
        if (rst) begin
            wa_q <= '0;
            wd_q <= '0;
        end else if (accept) begin
            wa_q <= word_addr;
            wd_q <= wdata;
        end
    end

    assign piece    = wide ? wd_q[16*sub_idx[0] +: 16] : {8'h00, wd_q[8*sub_idx +: 8]};
    assign mem_addr = active ? wa_q : '0;
    assign mem_ba   = active ? (wide ? {sub_idx[0], 1'b0} : sub_idx) : 2'b00;
    assign mem_dout = (active && wr) ? piece : '0;

    for (genvar k = 0; k < NBYTE; k++) begin : g_byte
        localparam logic [1:0] KI = 2'(k);
        localparam logic       KH = 1'(k / 2);
        logic hit;
        assign hit = wide ? (sub_idx[0] == KH) : (sub_idx == KI);
        always_ff @(posedge clk) begin
            if (rst) begin
                rbytes[k] <= '0;
            end else if (sample_en && hit) begin
                rbytes[k] <= wide ? din[8*(k%2) +: 8] : din[7:0];
            end
        end
    end

    assign rdata = rbytes;
endmodule

// File: rtl/asram_seq.sv
module asram_seq
    import asram_pkg::*;
#(
    parameter int NCS    = 4,
    parameter int ADDR_W = 22
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NCS*CFG_W-1:0]  cfg_flat,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [WORD_W-1:0]     req_addr,
    input  logic [WORD_W-1:0]     req_wdata,
    input  logic                  req_write,
    input  logic [$clog2(NCS)-1:0] req_cs,
    output logic                  rsp_valid,
    output logic [WORD_W-1:0]     rsp_rdata,
    input  logic                  strobe_extend,
    output logic [NCS-1:0]        mem_cs_n,
    output logic                  mem_oe_n,
    output logic                  mem_we_n,
    output logic                  mem_rw,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic [1:0]            mem_ba,
    output logic [DQ_W-1:0]       mem_dout,
    output logic                  mem_doe,
    input  logic [DQ_W-1:0]       mem_din
);
    localparam int CS_W = $clog2(NCS);

    asram_cfg_t      cfg_arr [NCS];
    asram_cfg_t      cfg_sel;
    phase_e          phase;
    logic [1:0]      sub_idx;
    logic [CS_W-1:0] cur_cs;
    logic            cur_wr, cur_ss, cur_wide;
    logic            sample_en, done, active, strobing;
    logic            unused_addr;

    for (genvar i = 0; i < NCS; i++) begin : g_cfg
        assign cfg_arr[i] = cfg_flat[i*CFG_W +: CFG_W];
    end
    assign cfg_sel     = cfg_arr[req_cs];
    assign unused_addr = ^{req_addr[WORD_W-1:ADDR_W+2], req_addr[1:0]};

    asram_ctrl #(.NCS(NCS), .CS_W(CS_W)) u_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_cs(req_cs), .req_cfg(cfg_sel), .strobe_extend(strobe_extend),
        .req_ready(req_ready), .phase(phase), .sub_idx(sub_idx),
        .cur_cs(cur_cs), .cur_wr(cur_wr), .cur_ss(cur_ss), .cur_wide(cur_wide),
        .sample_en(sample_en), .done(done)
    );

    assign active   = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
    assign strobing = (phase == PH_STROBE);

    asram_lane #(.ADDR_W(ADDR_W)) u_lane (
        .clk(clk), .rst(rst), .accept(req_valid && req_ready),
        .word_addr(req_addr[ADDR_W+1:2]), .wdata(req_wdata),
        .wide(cur_wide), .sub_idx(sub_idx), .active(active), .wr(cur_wr),
        .sample_en(sample_en), .din(mem_din),
        .mem_addr(mem_addr), .mem_ba(mem_ba), .mem_dout(mem_dout),
        .rdata(rsp_rdata)
    );

    for (genvar i = 0; i < NCS; i++) begin : g_cs
        assign mem_cs_n[i] = !((cur_cs == CS_W'(i)) && (cur_ss ? strobing : active));
    end

    assign mem_oe_n = !(strobing && !cur_wr);
    assign mem_we_n = !(strobing && cur_wr);
    assign mem_rw   = !(active && cur_wr);
    assign mem_doe  = active && cur_wr;

    always_ff @(posedge clk) begin
        if (rst) rsp_valid <= 1'b0;
        else     rsp_valid <= done && !cur_wr;
    end
endmodule

// File: rtl/asram_seq_chk.sv
module asram_seq_chk #(
    parameter int NCS    = 4,
    parameter int ADDR_W = 22
) (
    input logic              clk,
    input logic              rst,
    input logic [NCS-1:0]    mem_cs_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic              mem_rw,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_doe,
    input logic              req_ready,
    input logic              rsp_valid
);
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(!mem_oe_n && !mem_we_n));                                   // R5
    AST_OE_IS_READ: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> mem_rw);                                        // R5
    AST_ONE_SELECT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~mem_cs_n));                                         // R3
    AST_READY_QUIET: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (&mem_cs_n && mem_oe_n && mem_we_n && mem_rw)); // R10
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);                                    // R6
    AST_DRIVE_WRITE: assert property (@(posedge clk) disable iff (rst)
        mem_doe |-> !mem_rw);                                         // R11
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        (!mem_oe_n && $past(!mem_oe_n)) |-> $stable(mem_addr));       // R7
endmodule

bind asram_seq asram_seq_chk #(.NCS(NCS), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_rw(mem_rw), .mem_addr(mem_addr),
    .mem_doe(mem_doe), .req_ready(req_ready), .rsp_valid(rsp_valid)
);

// File: tb/asram_seq_tb.sv
module asram_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NCS = 4;
    localparam int CW  = 30;

    logic clk = 0, rst = 1;
    logic [NCS*CW-1:0] cfg_flat = '0;
    logic req_valid = 0, req_ready, req_write = 0;
    logic [31:0] req_addr = 0, req_wdata = 0;
    logic [1:0] req_cs = 0;
    logic rsp_valid;
    logic [31:0] rsp_rdata;
    logic strobe_extend;
    logic [3:0] mem_cs_n;
    logic mem_oe_n, mem_we_n, mem_rw, mem_doe;
    logic [21:0] mem_addr;
    logic [1:0] mem_ba;
    logic [15:0] mem_dout, mem_din;

    int errors = 0, checks = 0, cycles = 0, ext_budget = 0;
    bit running = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    asram_seq u_dut (.*);

    function automatic logic [15:0] pat(logic [21:0] a, logic [1:0] b);
        return {a[5:0], b, a[7:0] ^ {b, b, b, b}};
    endfunction

    assign mem_din = !mem_oe_n ? pat(mem_addr, mem_ba) : 16'hDEAD;
    assign strobe_extend = (ext_budget > 0) && (!mem_oe_n || !mem_we_n);
    always @(posedge clk) if (strobe_extend) ext_budget <= ext_budget - 1;

    int c_ss[4], c_wd[4], c_ta[4], c_rs[4], c_rt[4], c_rh[4], c_ws[4], c_wt[4], c_wh[4];

    // R1: configuration layout {ss, wide, ta, rs, rstb, rh, ws, wstb, wh}
    task automatic set_cfg(int i, int ss, int wd, int ta, int rs, int rt, int rh,
                           int ws, int wt, int wh);
        c_ss[i]=ss; c_wd[i]=wd; c_ta[i]=ta; c_rs[i]=rs; c_rt[i]=rt; c_rh[i]=rh;
        c_ws[i]=ws; c_wt[i]=wt; c_wh[i]=wh;
        cfg_flat[i*CW +: CW] = {1'(ss), 1'(wd), 4'(ta), 4'(rs), 4'(rt), 4'(rh),
                                4'(ws), 4'(wt), 4'(wh)};
    endtask

    typedef struct {
        logic [3:0] cs_n; logic oe_n, we_n, rw, doe, rdy, rsp;
        logic [21:0] addr; logic [1:0] ba; logic [15:0] dout; logic [31:0] rdata;
        string tag;
    } exp_t;
    exp_t q[$];

    function automatic exp_t idle(logic rdy, string tag);
        exp_t e;
        e.cs_n = 4'hF; e.oe_n = 1; e.we_n = 1; e.rw = 1; e.doe = 0; e.rdy = rdy;
        e.rsp = 0; e.addr = 0; e.ba = 0; e.dout = 0; e.rdata = 0; e.tag = tag;
        return e;
    endfunction

    bit m_last_vld = 0; int m_last_cs = 0; bit m_last_wr = 0;

    task automatic model_req(int cs, bit wr, logic [31:0] a, logic [31:0] d, int ext);
        bit turn = !(m_last_vld && m_last_cs == cs && m_last_wr == wr);
        int s  = wr ? c_ws[cs] : c_rs[cs];
        int st = wr ? c_wt[cs] : c_rt[cs];
        int h  = wr ? c_wh[cs] : c_rh[cs];
        int nsub = c_wd[cs] ? 2 : 4;
        logic [31:0] rd = 0;
        logic [21:0] wa = a[23:2];
        exp_t e;
        if (turn) for (int k = 0; k <= c_ta[cs]; k++) q.push_back(idle(0, "R2"));
        for (int sb = 0; sb < nsub; sb++) begin
            e = idle(0, "R1");
            e.addr = wa;
            e.ba = c_wd[cs] ? {sb[0], 1'b0} : sb[1:0];
            e.rw = !wr; e.doe = wr;
            e.dout = !wr ? 16'h0 : (c_wd[cs] ? d[16*sb +: 16] : {8'h0, d[8*sb +: 8]});
            e.cs_n = c_ss[cs] ? 4'hF : ~(4'b1 << cs);
            e.tag = c_ss[cs] ? "R4" : "R3";
            for (int k = 0; k <= s; k++) q.push_back(e);
            e.cs_n = ~(4'b1 << cs); e.oe_n = wr; e.we_n = !wr;
            e.tag = (ext > 0 && sb == 0) ? "R8" : "R1";
            for (int k = 0; k <= st + ((sb == 0) ? ext : 0); k++) q.push_back(e);
            e.cs_n = c_ss[cs] ? 4'hF : ~(4'b1 << cs); e.oe_n = 1; e.we_n = 1;
            e.tag = c_ss[cs] ? "R4" : "R3";
            for (int k = 0; k <= h; k++) q.push_back(e);
            if (!wr) begin
                if (c_wd[cs]) rd[16*sb +: 16] = pat(wa, {sb[0], 1'b0});
                else          rd[8*sb +: 8]   = pat(wa, sb[1:0]) & 16'h00FF;
            end
        end
        e = idle(1, "R6"); e.rsp = !wr; e.rdata = rd;
        q.push_back(e);
        m_last_vld = 1; m_last_cs = cs; m_last_wr = wr;
    endtask

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s at cycle %0d: actual=%h expected=%h", tag, what, cycles, act, exp);
        end
    endtask

    always @(negedge clk) if (running) begin
        exp_t e;
        e = (q.size() > 0) ? q.pop_front() : idle(1, "R10");
        chk(e.tag == "R4" ? "R4" : "R3", "cs_n", 32'(mem_cs_n), 32'(e.cs_n));
        chk("R5", "oe_n", 32'(mem_oe_n), 32'(e.oe_n));
        chk("R5", "we_n", 32'(mem_we_n), 32'(e.we_n));
        chk("R5", "rw", 32'(mem_rw), 32'(e.rw));
        chk("R7", "addr", 32'(mem_addr), 32'(e.addr));
        chk("R7", "ba", 32'(mem_ba), 32'(e.ba));
        chk("R11", "dout", 32'(mem_dout), 32'(e.dout));
        chk("R11", "doe", 32'(mem_doe), 32'(e.doe));
        chk(e.tag == "R2" ? "R2" : "R10", "ready", 32'(req_ready), 32'(e.rdy));
        chk(e.tag == "R8" ? "R8" : "R6", "rsp_valid", 32'(rsp_valid), 32'(e.rsp));
        if (e.rsp) chk("R6", "rsp_rdata", rsp_rdata, e.rdata);
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++; checks++;
            $display("FAIL R10 watchdog: actual=%0d expected<=20000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic do_req(int cs, bit wr, logic [31:0] a, logic [31:0] d, int ext);
        while (q.size() != 0) @(negedge clk);
        @(negedge clk);
        req_cs = 2'(cs); req_write = wr; req_addr = a; req_wdata = d;
        ext_budget = ext; req_valid = 1;
        @(posedge clk);
        model_req(cs, wr, a, d, ext);
        #1 req_valid = 0;
    endtask

    initial begin
        set_cfg(0, 0, 1, 2, 1, 2, 1, 0, 1, 0);
        set_cfg(1, 1, 0, 0, 0, 0, 0, 2, 1, 1);
        set_cfg(2, 0, 0, 3, 2, 3, 2, 1, 0, 2);
        set_cfg(3, 1, 1, 1, 0, 1, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        rst = 0;
        running = 1;
        @(negedge clk);
        do_req(0, 0, 32'h0012_3458, 0, 0);            // R2 first after reset, R7 16-bit
        do_req(0, 0, 32'h0000_0A10, 0, 0);            // R2 no turnaround read-read
        do_req(0, 1, 32'h0000_0104, 32'hCAFE_F00D, 0); // R11 write, turnaround
        do_req(0, 1, 32'h0000_0108, 32'h1234_5678, 0); // R2 write-write
        do_req(1, 1, 32'h0000_3F0C, 32'hA1B2_C3D4, 0); // R4 select-strobe 8-bit write
        do_req(1, 0, 32'h0000_3F0C, 0, 0);            // R2 zero field still one cycle
        do_req(2, 0, 32'h00AB_CDE0, 0, 3);            // R8 extended read, R3 normal 8-bit
        do_req(2, 1, 32'h0000_0040, 32'h0F1E_2D3C, 2); // R8 extended write
        do_req(3, 0, 32'h0003_0300, 0, 0);            // R4 16-bit select-strobe read
        do_req(3, 1, 32'h0003_0304, 32'h5566_7788, 0);
        do_req(0, 0, 32'h0000_7770, 0, 0);
        @(negedge clk);
        set_cfg(0, 1, 0, 5, 3, 3, 3, 3, 3, 3);        // R9 change mid-request
        do_req(0, 0, 32'h0000_7774, 0, 0);            // R9 new config applies
        do_req(2, 0, 32'h0000_1FFC, 0, 0);
        while (q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule